// File: doc/BRIEF.md
# Flash Block Erase-Verify Sequencer

This block is a hardware sequencer that carries out the complete erase of one flash block and then confirms the result. A single start request arrives with a block-select vector. The sequencer then drives the flash control levels in a fixed order: software write enable, erase setup, the erase pulse itself and erase verify. It also drives a one-hot block-select output and a watchdog-enable level that surrounds the erase pulse. Every interval between two control edges is timed by one shared, loadable cycle counter. Each interval length is a separate parameter counted in clock cycles, and the erase pulse may be far longer than the others.

After the erase, the sequencer scans the selected block one data word at a time through a simple memory port. The scan starts at the block's first word. Before each read it issues a dummy write of all ones, then waits a read-setup delay. A word passes only when every bit reads as one. If any word fails, the scan stops and the sequencer erases again. It does this up to a parameterised number of attempts and then gives up. The block is never pre-programmed to zeros. One run erases exactly one block, so erasing several blocks takes several runs.

The result appears as a one-cycle completion pulse. A pass or fail flag then holds until the next accepted start.

Top module: `flash_blk_erase_seq`

## Requirements
- R1: A start while idle is accepted only when exactly one bit of `blk_sel_i` is set. With zero or several bits set, the sequencer stays idle, `busy_o` stays 0 and no control level rises.
- R2: Entry order: `swe_o` rises and holds for T_SWE_SET cycles. Then one cycle of block select and one cycle of watchdog on follow. Then `esu_o` rises, so `esu_o` first rises T_SWE_SET+2 cycles after `swe_o`. After the erase pulse, `ers_o` falls and T_ERS_HOLD cycles pass. Then `esu_o` falls and T_ESU_HOLD cycles pass, then one watchdog-off cycle. Then `ev_o` rises, so `ev_o` rises T_ERS_HOLD+T_ESU_HOLD+1 cycles after `ers_o` falls.
- R3: Each erase pulse (`ers_o` high) lasts exactly T_ERASE cycles. During the pulse, `swe_o`, `esu_o` and `wdt_en_o` are all high and `blk_en_o` equals the accepted select vector.
- R4: The verify scan starts at word address block_index*WORDS_PER_BLOCK. Block_index is the position of the single set select bit, with bit 0 as block 0. For each word, `mem_wr_o` pulses for one cycle with `mem_wdata_o` all ones. Then T_RD_SETUP cycles pass, then `mem_rd_o` pulses for one cycle. `mem_rdata_i` is sampled in that same cycle, and the address then steps by one.
- R5: A word passes only when `mem_rdata_i` is all ones. The run succeeds only after the last word of the block (offset WORDS_PER_BLOCK-1) has passed.
- R6: The scan stops at the first failing word. The attempt count starts at 1 for every accepted start. If the count is below MAX_TRIES, it increments and the sequence re-arms the watchdog and re-enters at the erase-setup step, without dropping `swe_o`.
- R7: If a word fails on attempt MAX_TRIES, the run ends with failure after exactly MAX_TRIES erase pulses.
- R8: `done_o` is high for exactly one cycle per run. In that cycle exactly one of `pass_o` and `fail_o` is high. That flag holds after `done_o` until the next accepted start.
- R9: A start request while `busy_o` is high has no effect. The running block and its result are unchanged, and no second run follows.
- R10: Exit order: after the deciding read, `ev_o` falls and T_EV_CLR cycles pass. Then `swe_o` and `blk_en_o` fall and T_SWE_CLR cycles pass. `done_o` comes T_EV_CLR+T_SWE_CLR+1 cycles after the cycle of the deciding read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a run |
| blk_sel_i | input | NUM_BLOCKS | Block to erase, must be one-hot |
| swe_o | output | 1 | Software write-enable level |
| esu_o | output | 1 | Erase-setup level |
| ers_o | output | 1 | Erase pulse level |
| ev_o | output | 1 | Erase-verify level |
| wdt_en_o | output | 1 | Watchdog enable around the erase |
| blk_en_o | output | NUM_BLOCKS | One-hot block select to the array |
| mem_addr_o | output | ADDR_W | Word address of the verify scan |
| mem_wr_o | output | 1 | Dummy-write strobe before each read |
| mem_wdata_o | output | DATA_W | Dummy-write data, all ones |
| mem_rd_o | output | 1 | Read strobe, data sampled in the same cycle |
| mem_rdata_i | input | DATA_W | Read data word |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Last run verified clean |
| fail_o | output | 1 | Last run ran out of attempts |

## Verification
The bench's memory model returns all ones for a word only after a set number of erase pulses have been seen. One word of the block can be given extra pulses before it clears. The table walks blocks that clear on the first pulse, on a middle pulse and exactly on the last allowed pulse. The pass-at-limit row and the fail-beyond-limit row separate an off-by-one in the attempt bound. A row where only a late word lags shows whether the scan really stops at the first failing word and restarts from the block start. A row where only the last word never clears separates a scan that stops one word short from one that covers the block. Directed cases cover illegal select patterns and a start issued in the middle of a run.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SWE_SET,
        ST_SEL,
        ST_WDT_ON,
        ST_ESU_SET,
        ST_ERASE,
        ST_ERS_HOLD,
        ST_ESU_HOLD,
        ST_WDT_OFF,
        ST_EV_SET,
        ST_DUMMY_WR,
        ST_RD_SETUP,
        ST_READ,
        ST_EV_CLR,
        ST_SWE_CLR,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic swe;
        logic esu;
        logic ers;
        logic ev;
        logic wdt;
        logic sel_en;
    } ctl_levels_t;

    // Control levels seen by the array for each sequencer state.
    function automatic ctl_levels_t levels_for(seq_state_e s);
        ctl_levels_t l;
        l.swe    = (s inside {ST_SWE_SET, ST_SEL, ST_WDT_ON, ST_ESU_SET, ST_ERASE,
                              ST_ERS_HOLD, ST_ESU_HOLD, ST_WDT_OFF, ST_EV_SET,
                              ST_DUMMY_WR, ST_RD_SETUP, ST_READ, ST_EV_CLR});
        l.sel_en = (s inside {ST_SEL, ST_WDT_ON, ST_ESU_SET, ST_ERASE, ST_ERS_HOLD,
                              ST_ESU_HOLD, ST_WDT_OFF, ST_EV_SET, ST_DUMMY_WR,
                              ST_RD_SETUP, ST_READ, ST_EV_CLR});
        l.wdt    = (s inside {ST_WDT_ON, ST_ESU_SET, ST_ERASE, ST_ERS_HOLD, ST_ESU_HOLD});
        l.esu    = (s inside {ST_ESU_SET, ST_ERASE, ST_ERS_HOLD});
        l.ers    = (s == ST_ERASE);
        l.ev     = (s inside {ST_EV_SET, ST_DUMMY_WR, ST_RD_SETUP, ST_READ});
        return l;
    endfunction

    // Width of an index into n items, never zero.
    function automatic int idx_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fes_onehot_check.sv
module fes_onehot_check
    import flash_erase_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = idx_width(N)
) (
    input  logic [N-1:0]     sel,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    localparam int CNT_W = $clog2(N + 1);

    logic [CNT_W-1:0] ones;

    always_comb begin
        ones = '0;
        idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) begin
                ones = ones + CNT_W'(1);
                idx  = IDX_W'(i);
            end
        end
        valid = (ones == CNT_W'(1));
    end
endmodule

// File: rtl/fes_wait_timer.sv
module fes_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/fes_addr_scan.sv
module fes_addr_scan
    import flash_erase_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int IDX_W  = 2,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              step,
    input  logic [IDX_W-1:0]  blk_idx,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam int OFF_W = idx_width(WORDS);

    logic [OFF_W-1:0] off_q;

    always_ff @(posedge clk) begin
        if (rst || init) begin
            off_q <= '0;
        end else if (step) begin
            off_q <= off_q + OFF_W'(1);
        end
    end

    assign addr = ADDR_W'(blk_idx) * ADDR_W'(WORDS) + ADDR_W'(off_q);
    assign last = (off_q == OFF_W'(WORDS - 1));
endmodule

// File: rtl/flash_blk_erase_seq.sv
module flash_blk_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int NUM_BLOCKS      = 4,
    parameter int WORDS_PER_BLOCK = 8,
    parameter int DATA_W          = 16,
    parameter int MAX_TRIES       = 3,
    parameter int T_SWE_SET       = 3,
    parameter int T_ESU_SET       = 2,
    parameter int T_ERASE         = 40,
    parameter int T_ERS_HOLD      = 2,
    parameter int T_ESU_HOLD      = 2,
    parameter int T_EV_SET        = 2,
    parameter int T_RD_SETUP      = 2,
    parameter int T_EV_CLR        = 2,
    parameter int T_SWE_CLR       = 3,
    parameter int ADDR_W          = idx_width(NUM_BLOCKS * WORDS_PER_BLOCK)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [NUM_BLOCKS-1:0] blk_sel_i,
    output logic                  swe_o,
    output logic                  esu_o,
    output logic                  ers_o,
    output logic                  ev_o,
    output logic                  wdt_en_o,
    output logic [NUM_BLOCKS-1:0] blk_en_o,
    output logic [ADDR_W-1:0]     mem_addr_o,
    output logic                  mem_wr_o,
    output logic [DATA_W-1:0]     mem_wdata_o,
    output logic                  mem_rd_o,
    input  logic [DATA_W-1:0]     mem_rdata_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  pass_o,
    output logic                  fail_o
);
    localparam int WAIT_SUM = T_SWE_SET + T_ESU_SET + T_ERASE + T_ERS_HOLD + T_ESU_HOLD
                            + T_EV_SET + T_RD_SETUP + T_EV_CLR + T_SWE_CLR;
    localparam int CNT_W    = $clog2(WAIT_SUM + 1);
    localparam int TRY_W    = $clog2(MAX_TRIES + 1);
    localparam int IDX_W    = idx_width(NUM_BLOCKS);

    seq_state_e            state_q, state_d;
    ctl_levels_t           lv;
    logic [NUM_BLOCKS-1:0] sel_q;
    logic [IDX_W-1:0]      idx_q, idx_in;
    logic [TRY_W-1:0]      tries_q;
    logic                  verdict_q, pass_q, fail_q;
    logic                  sel_ok, tmr_exp, word_ok, scan_last;
    logic [CNT_W-1:0]      wait_len;
    logic                  accept;

    fes_onehot_check #(.N(NUM_BLOCKS), .IDX_W(IDX_W)) u_selchk (
        .sel   (blk_sel_i),
        .valid (sel_ok),
        .idx   (idx_in)
    );

    fes_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (state_d != state_q),
        .load_val (wait_len),
        .expired  (tmr_exp)
    );

    fes_addr_scan #(.WORDS(WORDS_PER_BLOCK), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_scan (
        .clk     (clk),
        .rst     (rst),
        .init    (state_q == ST_WDT_OFF),
        .step    (state_q == ST_READ && word_ok && !scan_last),
        .blk_idx (idx_q),
        .addr    (mem_addr_o),
        .last    (scan_last)
    );

    assign word_ok = &mem_rdata_i;
    assign accept  = (state_q == ST_IDLE) && start_i && sel_ok;

    // Length of the state about to be entered, minus one.
    always_comb begin
        case (state_d)
            ST_SWE_SET:  wait_len = CNT_W'(T_SWE_SET - 1);
            ST_ESU_SET:  wait_len = CNT_W'(T_ESU_SET - 1);
            ST_ERASE:    wait_len = CNT_W'(T_ERASE - 1);
            ST_ERS_HOLD: wait_len = CNT_W'(T_ERS_HOLD - 1);
            ST_ESU_HOLD: wait_len = CNT_W'(T_ESU_HOLD - 1);
            ST_EV_SET:   wait_len = CNT_W'(T_EV_SET - 1);
            ST_RD_SETUP: wait_len = CNT_W'(T_RD_SETUP - 1);
            ST_EV_CLR:   wait_len = CNT_W'(T_EV_CLR - 1);
            ST_SWE_CLR:  wait_len = CNT_W'(T_SWE_CLR - 1);
            default:     wait_len = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (accept) state_d = ST_SWE_SET;
            ST_SWE_SET:  if (tmr_exp) state_d = ST_SEL;
            ST_SEL:      state_d = ST_WDT_ON;
            ST_WDT_ON:   state_d = ST_ESU_SET;
            ST_ESU_SET:  if (tmr_exp) state_d = ST_ERASE;
            ST_ERASE:    if (tmr_exp) state_d = ST_ERS_HOLD;
            ST_ERS_HOLD: if (tmr_exp) state_d = ST_ESU_HOLD;
            ST_ESU_HOLD: if (tmr_exp) state_d = ST_WDT_OFF;
            ST_WDT_OFF:  state_d = ST_EV_SET;
            ST_EV_SET:   if (tmr_exp) state_d = ST_DUMMY_WR;
            ST_DUMMY_WR: state_d = ST_RD_SETUP;
            ST_RD_SETUP: if (tmr_exp) state_d = ST_READ;
            ST_READ:     state_d = (word_ok && !scan_last) ? ST_DUMMY_WR : ST_EV_CLR;
            ST_EV_CLR: begin
                if (tmr_exp) begin
                    if (verdict_q || tries_q >= TRY_W'(MAX_TRIES)) state_d = ST_SWE_CLR;
                    else                                            state_d = ST_WDT_ON;
                end
            end
            ST_SWE_CLR:  if (tmr_exp) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            sel_q     <= '0;
            idx_q     <= '0;
            tries_q   <= '0;
            verdict_q <= 1'b0;
            pass_q    <= 1'b0;
            fail_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                sel_q   <= blk_sel_i;
                idx_q   <= idx_in;
                tries_q <= TRY_W'(1);
                pass_q  <= 1'b0;
                fail_q  <= 1'b0;
            end
            if (state_q == ST_READ) begin
                verdict_q <= word_ok && scan_last;
            end
            if (state_q == ST_EV_CLR && state_d == ST_WDT_ON) begin
                tries_q <= tries_q + TRY_W'(1);
            end
            if (state_q == ST_SWE_CLR && state_d == ST_DONE) begin
                pass_q <= verdict_q;
                fail_q <= !verdict_q;
            end
        end
    end

    assign lv          = levels_for(state_q);
    assign swe_o       = lv.swe;
    assign esu_o       = lv.esu;
    assign ers_o       = lv.ers;
    assign ev_o        = lv.ev;
    assign wdt_en_o    = lv.wdt;
    assign blk_en_o    = lv.sel_en ? sel_q : '0;
    assign mem_wr_o    = (state_q == ST_DUMMY_WR);
    assign mem_rd_o    = (state_q == ST_READ);
    assign mem_wdata_o = {DATA_W{1'b1}};
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_DONE);
    assign pass_o      = pass_q;
    assign fail_o      = fail_q;
endmodule

// File: rtl/fes_seq_chk.sv
module fes_seq_chk #(
    parameter int NUM_BLOCKS = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start_i,
    input logic [NUM_BLOCKS-1:0] blk_sel_i,
    input logic                  swe_o,
    input logic                  esu_o,
    input logic                  ers_o,
    input logic                  ev_o,
    input logic                  wdt_en_o,
    input logic [NUM_BLOCKS-1:0] blk_en_o,
    input logic                  mem_wr_o,
    input logic                  mem_rd_o,
    input logic                  busy_o,
    input logic                  done_o,
    input logic                  pass_o,
    input logic                  fail_o
);
    // R1
    sel_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && $countones(blk_sel_i) != 1) |=> !busy_o);

    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(blk_en_o));

    // R3
    erase_context_chk: assert property (@(posedge clk) disable iff (rst)
        ers_o |-> (swe_o && esu_o && wdt_en_o && blk_en_o != '0));

    // R2
    setup_in_watchdog_chk: assert property (@(posedge clk) disable iff (rst)
        esu_o |-> wdt_en_o);

    // R4
    verify_apart_chk: assert property (@(posedge clk) disable iff (rst)
        ev_o |-> (!esu_o && !ers_o && !wdt_en_o));

    // R4
    strobe_in_verify_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_o || mem_rd_o) |-> ev_o);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    done_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (pass_o != fail_o));

    // R8
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pass_o && fail_o));

    // R10
    select_with_swe_chk: assert property (@(posedge clk) disable iff (rst)
        !swe_o |-> (blk_en_o == '0 && !ev_o));
endmodule

bind flash_blk_erase_seq fes_seq_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .blk_sel_i (blk_sel_i),
    .swe_o     (swe_o),
    .esu_o     (esu_o),
    .ers_o     (ers_o),
    .ev_o      (ev_o),
    .wdt_en_o  (wdt_en_o),
    .blk_en_o  (blk_en_o),
    .mem_wr_o  (mem_wr_o),
    .mem_rd_o  (mem_rd_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .fail_o    (fail_o)
);

// File: tb/flash_blk_erase_seq_tb.sv
`timescale 1ns/1ps
module flash_blk_erase_seq_tb;
    localparam int NB      = 4;
    localparam int WORDS   = 8;
    localparam int DW      = 16;
    localparam int TRIES   = 3;
    localparam int T_SWE   = 3;
    localparam int T_ERASE = 40;
    localparam int T_CE    = 2;
    localparam int T_CESU  = 2;
    localparam int T_CEV   = 2;
    localparam int T_CSWE  = 3;
    localparam int AW      = $clog2(NB * WORDS);

    typedef struct packed {
        logic [3:0] sel;
        logic [3:0] need;
        logic [2:0] bad;
        logic [3:0] extra;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{4'b0001, 4'd1, 3'd0, 4'd0},
        '{4'b0100, 4'd2, 3'd0, 4'd0},
        '{4'b1000, 4'd1, 3'd5, 4'd1},
        '{4'b0010, 4'd4, 3'd0, 4'd0},
        '{4'b0001, 4'd3, 3'd0, 4'd0},
        '{4'b0010, 4'd1, 3'd7, 4'd5}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [NB-1:0] blk_sel_i = '0;
    logic          swe_o, esu_o, ers_o, ev_o, wdt_en_o;
    logic [NB-1:0] blk_en_o;
    logic [AW-1:0] mem_addr_o;
    logic          mem_wr_o, mem_rd_o;
    logic [DW-1:0] mem_wdata_o, mem_rdata_i;
    logic          busy_o, done_o, pass_o, fail_o;

    always #4 clk = ~clk;

    flash_blk_erase_seq u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .blk_sel_i(blk_sel_i),
        .swe_o(swe_o), .esu_o(esu_o), .ers_o(ers_o), .ev_o(ev_o), .wdt_en_o(wdt_en_o),
        .blk_en_o(blk_en_o), .mem_addr_o(mem_addr_o), .mem_wr_o(mem_wr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rd_o(mem_rd_o), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
    );

    int errors = 0;
    int checks = 0;

    // Memory model: word clears after need (+extra for the lagging word) pulses.
    int need_cur = 1, bad_cur = 0, extra_cur = 0, pulses = 0;
    always_comb begin
        int w, thr;
        w = int'(mem_addr_o) % WORDS;
        thr = need_cur + ((w == bad_cur) ? extra_cur : 0);
        mem_rdata_i = (pulses >= thr) ? {DW{1'b1}} : {DW{1'b0}};
    end

    // Monitor, sampling pre-edge values.
    int cyc = 0;
    int nrd, nwr, ndone, wbad, width_bad, sel_bad, ers_run;
    int first_addr, last_addr, t_last_rd, t_done;
    int t_swe, t_esu, t_ers_fall, esu_gap, ev_gap;
    bit esu_seen, ev_seen;
    logic [NB-1:0] cur_sel;
    logic p_swe = 0, p_esu = 0, p_ers = 0, p_ev = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst) begin
            if (swe_o && !p_swe) t_swe = cyc;
            if (esu_o && !p_esu && !esu_seen) begin esu_seen = 1; esu_gap = cyc - t_swe; end
            if (ers_o && !p_ers) pulses++;
            if (ers_o) begin
                ers_run++;
                if (blk_en_o != cur_sel) sel_bad++;
            end
            if (!ers_o && p_ers) begin
                if (ers_run != T_ERASE) width_bad++;
                ers_run = 0;
                t_ers_fall = cyc;
            end
            if (ev_o && !p_ev && !ev_seen) begin ev_seen = 1; ev_gap = cyc - t_ers_fall; end
            if (mem_wr_o) begin
                nwr++;
                if (mem_wdata_o != {DW{1'b1}}) wbad++;
            end
            if (mem_rd_o) begin
                if (nrd == 0) first_addr = int'(mem_addr_o);
                last_addr = int'(mem_addr_o);
                t_last_rd = cyc;
                nrd++;
            end
            if (done_o) begin ndone++; t_done = cyc; end
        end
        p_swe = swe_o; p_esu = esu_o; p_ers = ers_o; p_ev = ev_o;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        nrd = 0; nwr = 0; ndone = 0; wbad = 0; width_bad = 0; sel_bad = 0; ers_run = 0;
        first_addr = -1; last_addr = -1; t_last_rd = 0; t_done = 0;
        t_swe = 0; t_esu = 0; t_ers_fall = 0; esu_gap = 0; ev_gap = 0;
        esu_seen = 0; ev_seen = 0; pulses = 0;
    endtask

    function automatic void predict(input int need, input int bad, input int extra,
                                    output bit ok, output int np, output int nr, output int loff);
        ok = 0; np = 0; nr = 0; loff = 0;
        for (int a = 1; a <= TRIES && !ok; a++) begin
            np = a;
            ok = 1;
            for (int w = 0; w < WORDS; w++) begin
                nr++;
                loff = w;
                if (a < need + ((w == bad) ? extra : 0)) begin ok = 0; break; end
            end
        end
    endfunction

    function automatic int sel_index(input logic [NB-1:0] s);
        int r = 0;
        for (int i = 0; i < NB; i++) if (s[i]) r = i;
        return r;
    endfunction

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 5000 && !seen; i++) begin
            @(negedge clk);
            if (done_o) seen = 1;
        end
    endtask

    task automatic pulse_start(input logic [NB-1:0] s);
        @(negedge clk);
        start_i = 1'b1; blk_sel_i = s;
        @(negedge clk);
        start_i = 1'b0; blk_sel_i = '0;
    endtask

    task automatic run_vec(input vec_t v);
        bit ok, seen;
        int np, nr, loff, base;
        need_cur = int'(v.need); bad_cur = int'(v.bad); extra_cur = int'(v.extra);
        cur_sel = v.sel;
        predict(need_cur, bad_cur, extra_cur, ok, np, nr, loff);
        base = sel_index(v.sel) * WORDS;
        @(negedge clk);
        clear_mon();
        pulse_start(v.sel);
        wait_done(seen);
        chk(seen, "R8", "done seen", int'(seen), 1);
        chk(pass_o == ok, "R5", "pass flag", int'(pass_o), int'(ok));
        chk(fail_o == !ok, "R7", "fail flag", int'(fail_o), int'(!ok));
        @(negedge clk);
        chk(!done_o && ndone == 1, "R8", "done width", ndone, 1);
        chk(pass_o == ok && fail_o == !ok, "R8", "verdict held", int'(pass_o), int'(ok));
        chk(pulses == np, "R6", "erase pulses", pulses, np);
        chk(nrd == nr, "R6", "read count", nrd, nr);
        chk(nwr == nr && wbad == 0, "R4", "dummy writes", nwr, nr);
        chk(first_addr == base, "R4", "first address", first_addr, base);
        chk(last_addr == base + loff, "R5", "last address", last_addr, base + loff);
        chk(width_bad == 0 && sel_bad == 0, "R3", "pulse width/select", width_bad + sel_bad, 0);
        chk(esu_gap == T_SWE + 2, "R2", "swe->esu gap", esu_gap, T_SWE + 2);
        chk(ev_gap == T_CE + T_CESU + 1, "R2", "ers->ev gap", ev_gap, T_CE + T_CESU + 1);
        chk(t_done - t_last_rd == T_CEV + T_CSWE + 1, "R10", "read->done gap",
            t_done - t_last_rd, T_CEV + T_CSWE + 1);
        chk(!swe_o && blk_en_o == '0 && !busy_o, "R10", "levels off at end", int'(swe_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit seen;
        clear_mon();
        cur_sel = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(!busy_o && !swe_o && !esu_o && !ers_o && !ev_o && !wdt_en_o && blk_en_o == '0
            && !done_o && !pass_o && !fail_o && !mem_wr_o && !mem_rd_o,
            "R1", "reset state", int'(busy_o), 0);

        // R1: illegal selects refused
        pulse_start(4'b0000);
        repeat (5) @(negedge clk);
        chk(!busy_o && !swe_o, "R1", "zero select refused", int'(busy_o), 0);
        pulse_start(4'b0101);
        repeat (5) @(negedge clk);
        chk(!busy_o && !swe_o && blk_en_o == '0, "R1", "two-bit select refused", int'(busy_o), 0);

        // Table of vectors
        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R8: verdict holds after a refused start
        pulse_start(4'b1100);
        repeat (3) @(negedge clk);
        chk(pass_o == 1'b0 && fail_o == 1'b1, "R8", "verdict kept after refused start",
            int'(fail_o), 1);

        // R9: start while busy is ignored
        need_cur = 1; bad_cur = 0; extra_cur = 0; cur_sel = 4'b0001;
        @(negedge clk);
        clear_mon();
        pulse_start(4'b0001);
        repeat (10) @(negedge clk);
        pulse_start(4'b1000);
        wait_done(seen);
        chk(seen && pass_o, "R9", "run completes", int'(pass_o), 1);
        chk(first_addr == 0 && sel_bad == 0, "R9", "block unchanged", first_addr, 0);
        repeat (80) @(negedge clk);
        chk(ndone == 1 && !busy_o && nrd == WORDS, "R9", "no second run", ndone, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule